// File: doc/BRIEF.md
# MDIO Management Master

This block drives a two-wire management link to external PHY devices. Software programs a clock-control word with the MDC divider and the MDIO output hold time. It then writes one 32-bit command word into the data register. That write launches a complete frame on the MDC and MDIO pins: a run of preamble ones, then the command word, most significant bit first. When the frame ends, a sticky completion event is raised. For a read, the sixteen bits returned by the PHY replace the low half of the data register.

The MDIO pad is tri-state. The block supplies an output value and an output enable, and takes the pad's input value back. During the turnaround and data bits of a read, the output enable is released so the PHY can drive the line. MDC runs only while a frame is in flight and rests low otherwise.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, the output enable is low, the MDIO output is high, the event output is low, and all three registers read zero.
- R2: The registers are data/command at address 0, clock control at address 1 and event at address 2. Read data appears on the bus one clock after the address is presented. The clock-control divider field S occupies bits [6:1] and reads back; other bits read zero except the hold field. While a frame runs, MDC has a period of exactly 2*S system clocks.
- R3: The hold field H occupies bits [10:8]. After each falling MDC edge, the MDIO output and its enable change exactly H+1 system clocks later.
- R4: A frame is 32 ones followed by the command word's bits 31 down to 0. The frame has 64 rising MDC edges, and MDIO is valid at each rising edge. The command layout is: start [31:30], opcode [29:28] (10 = read, 01 = write), PHY address [27:23], register address [22:18], turnaround [17:16], write data [15:0].
- R5: In a read frame, the output enable is low from bit 46 (the first turnaround bit) to the end of the frame. The input is sampled on the rising MDC edge of each of the last 16 bits. After completion, the data register holds the command's upper half and the sampled value in its low half.
- R6: After a write frame completes, the data register still holds the command word written.
- R7: Completion sets event bit 0, and the event output mirrors that bit. Writing 1 to bit 0 of the event register clears it; writing 0 leaves it set.
- R8: A write to the data register while a frame is in progress is ignored. It launches no further frame and leaves the data register unchanged.
- R9: While the divider field is zero, a write to the data register is ignored. MDC stays low, no event is raised, and the register keeps its previous value.
- R10: Once a frame has finished, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| mdio_i | input | 1 | Value seen on the MDIO pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mii_evt_o | output | 1 | Sticky completion event |

## Verification
The checks assume that the hold time plus one is shorter than the divider value. Under that condition each output update lands inside the MDC low phase. They also assume that clock control is not rewritten while a frame is running. The stimulus keeps to both: every divider and hold pair in the vector table satisfies the inequality, and clock control is written only while the block is idle. The bench models the PHY as a responder. It drives the pad input only after a falling MDC edge in the data phase of a read, and leaves it high at all other times.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CLK  = 2'd1;
  localparam logic [1:0] ADDR_EVT  = 2'd2;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  localparam int SPD_LSB  = 1;
  localparam int HOLD_LSB = 8;
  localparam int CMD_W    = 32;
  localparam int RDAT_W   = 16;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [1:0]  ta;
    logic [15:0] data;
  } mgmt_cmd_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SPD_W-1:0] div,
  output logic             mdc,
  output logic             rise_now,
  output logic             fall_now
);

  logic [SPD_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (div != '0) && (cnt == div - SPD_W'(1));
  assign rise_now = tick && !mdc;
  assign fall_now = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + SPD_W'(1);
    end
  end

endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int HOLD_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [HOLD_W-1:0] hold,
  input  logic              rise_now,
  input  logic              fall_now,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              is_rd,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [RDAT_W-1:0] rx_data
);

  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 14;
  localparam int DAT_POS   = PRE_LEN + 16;
  localparam int LAST_POS  = FRAME_LEN - 1;

  logic [FRAME_LEN-1:0] shreg;
  logic [CNT_W-1:0]     bitn;
  logic                 pend;
  logic [HOLD_W-1:0]    hcnt;
  mgmt_cmd_t            cmd_s;

  assign cmd_s = mgmt_cmd_t'(cmd);
  assign done  = busy && fall_now && (bitn == CNT_W'(LAST_POS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bitn    <= '0;
      shreg   <= '0;
      pend    <= 1'b0;
      hcnt    <= '0;
      is_rd   <= 1'b0;
      rx_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      bitn  <= '0;
      shreg <= {{PRE_LEN{1'b1}}, cmd};
      pend  <= 1'b1;
      hcnt  <= '0;
      is_rd <= (cmd_s.op == OPC_READ);
    end else if (busy) begin
      if (pend) begin
        if (hcnt == hold) begin
          mdio_o  <= shreg[FRAME_LEN-1];
          mdio_oe <= !(is_rd && (bitn >= CNT_W'(TA_POS)));
          shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
          pend    <= 1'b0;
        end else begin
          hcnt <= hcnt + HOLD_W'(1);
        end
      end
      if (rise_now && is_rd && (bitn >= CNT_W'(DAT_POS))) begin
        rx_data <= {rx_data[RDAT_W-2:0], mdio_i};
      end
      if (fall_now) begin
        if (bitn == CNT_W'(LAST_POS)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          pend    <= 1'b0;
        end else begin
          bitn <= bitn + CNT_W'(1);
          pend <= 1'b1;
          hcnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
#(
  parameter int SPD_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [CMD_W-1:0]  bus_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_rd,
  input  logic [RDAT_W-1:0] rx_data,
  output logic              start,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [SPD_W-1:0]  spd,
  output logic [HOLD_W-1:0] hold,
  output logic              evt,
  output logic [CMD_W-1:0]  rdata
);

  logic             clr_evt;
  logic [CMD_W-1:0] clk_word;

  assign start   = bus_wr && (bus_addr == ADDR_DATA) && !busy && (spd != '0);
  assign clr_evt = bus_wr && (bus_addr == ADDR_EVT) && bus_wdata[0];

  always_comb begin
    clk_word = '0;
    clk_word[SPD_LSB +: SPD_W]   = spd;
    clk_word[HOLD_LSB +: HOLD_W] = hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      spd   <= '0;
      hold  <= '0;
      evt   <= 1'b0;
      rdata <= '0;
    end else begin
      if (start) begin
        cmd_q <= bus_wdata;
      end else if (done && done_rd) begin
        cmd_q[RDAT_W-1:0] <= rx_data;
      end
      if (bus_wr && (bus_addr == ADDR_CLK)) begin
        spd  <= bus_wdata[SPD_LSB +: SPD_W];
        hold <= bus_wdata[HOLD_LSB +: HOLD_W];
      end
      evt <= done || (evt && !clr_evt);
      case (bus_addr)
        ADDR_DATA: rdata <= cmd_q;
        ADDR_CLK:  rdata <= clk_word;
        ADDR_EVT:  rdata <= {{(CMD_W-1){1'b0}}, evt};
        default:   rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SPD_W   = 6,
  parameter int HOLD_W  = 3,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        mii_evt_o
);

  logic              start_w;
  logic              busy_w;
  logic              done_w;
  logic              rd_w;
  logic              rise_w;
  logic              fall_w;
  logic [RDAT_W-1:0] rx_w;
  logic [CMD_W-1:0]  cmd_w;
  logic [SPD_W-1:0]  spd_w;
  logic [HOLD_W-1:0] hold_w;

  mdio_csr #(.SPD_W(SPD_W), .HOLD_W(HOLD_W)) csr_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy_w), .done(done_w), .done_rd(rd_w),
    .rx_data(rx_w), .start(start_w), .cmd_q(cmd_w), .spd(spd_w),
    .hold(hold_w), .evt(mii_evt_o), .rdata(bus_rdata)
  );

  mdio_clk_div #(.SPD_W(SPD_W)) div_i (
    .clk(clk), .rst(rst), .run(busy_w), .div(spd_w), .mdc(mdc_o),
    .rise_now(rise_w), .fall_now(fall_w)
  );

  mdio_frame_shift #(.PRE_LEN(PRE_LEN), .HOLD_W(HOLD_W)) shf_i (
    .clk(clk), .rst(rst), .start(start_w), .cmd(bus_wdata), .hold(hold_w),
    .rise_now(rise_w), .fall_now(fall_w), .mdio_i(mdio_i), .busy(busy_w),
    .done(done_w), .is_rd(rd_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rx_data(rx_w)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic        wd0,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        evt,
  input logic        busy,
  input logic        done,
  input logic        start,
  input logic        rd,
  input logic        spd_zero,
  input logic [31:0] cmd
);

  // R10 / R2: MDC rests low whenever no frame runs
  a_r10_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R10: pad released when idle
  a_r10_oe_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R3: output updates land in the MDC low phase
  a_r3_change_in_low_phase: assert property (@(posedge clk) disable iff (rst)
    (busy && !$stable(mdio_o)) |-> !mdc);

  // R7: completion raises the event
  a_r7_evt_on_done: assert property (@(posedge clk) disable iff (rst)
    done |=> evt);

  // R7: event is sticky until a write of one
  a_r7_evt_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt && !(bus_wr && bus_addr == 2'd2 && wd0)) |=> evt);

  // R8: data register unchanged by writes during a frame
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && bus_wr && bus_addr == 2'd0) |=> $stable(cmd));

  // R6: write frame completion keeps the command word
  a_r6_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (done && !rd) |=> $stable(cmd));

  // R9: a zero divider never launches a frame
  a_r9_zero_speed: assert property (@(posedge clk) disable iff (rst)
    spd_zero |-> !start);

endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd0(bus_wdata[0]), .mdc(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .evt(mii_evt_o), .busy(busy_w), .done(done_w), .start(start_w),
  .rd(rd_w), .spd_zero(spd_w == '0), .cmd(cmd_w)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdio_i = 1'b1;
  logic        mdc_o, mdio_o, mdio_oe, mii_evt_o;

  always #4 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdio_i(mdio_i),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mii_evt_o(mii_evt_o)
  );

  int checks = 0;
  int fails  = 0;

  // fields: op, phy, reg, data, divider, hold, PHY reply
  localparam int NV = 5;
  localparam logic [52:0] VEC [NV] = '{
    {2'b01, 5'h01, 5'h00, 16'hA53C, 6'd4, 3'd1, 16'h0000},
    {2'b10, 5'h1F, 5'h02, 16'h0000, 6'd3, 3'd0, 16'h1234},
    {2'b01, 5'h10, 5'h1F, 16'h0F0F, 6'd6, 3'd3, 16'h0000},
    {2'b10, 5'h03, 5'h11, 16'h0000, 6'd8, 3'd5, 16'hBEEF},
    {2'b10, 5'h00, 5'h00, 16'h0000, 6'd2, 3'd0, 16'h8001}
  };

  // PHY-side monitor
  int          cyc = 0;
  int          rise_cnt = 0;
  int          last_rise = 0;
  int          per_min = 0;
  int          per_max = 0;
  int          since_fall = 0;
  int          hold_exp = 0;
  int          hold_bad = 0;
  int          hold_chk = 0;
  bit          fall_seen = 1'b0;
  logic [63:0] frame_bits = '0;
  logic [63:0] oe_bits = '0;
  logic [15:0] phy_val = '0;
  logic        mdc_p = 1'b0, o_p = 1'b1, oe_p = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mdc_o && !mdc_p) begin
      if (rise_cnt < 64) begin
        frame_bits[63-rise_cnt] = mdio_o;
        oe_bits[63-rise_cnt]    = mdio_oe;
      end
      if (rise_cnt > 0) begin
        if (per_min == 0 || cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      rise_cnt++;
    end
    if (!mdc_o && mdc_p) begin
      since_fall = 0;
      fall_seen  = 1'b1;
      if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_val[63-rise_cnt];
    end else if (fall_seen) begin
      since_fall++;
      if (mdio_o !== o_p || mdio_oe !== oe_p) begin
        hold_chk++;
        if (since_fall != hold_exp) hold_bad++;
        fall_seen = 1'b0;
      end
    end
    mdc_p = mdc_o; o_p = mdio_o; oe_p = mdio_oe;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic mon_clear(input int h, input logic [15:0] pv);
    @(posedge clk);
    rise_cnt = 0; per_min = 0; per_max = 0; hold_bad = 0; hold_chk = 0;
    fall_seen = 1'b0; frame_bits = '0; oe_bits = '0;
    hold_exp = h + 1; phy_val = pv; mdio_i = 1'b1;
  endtask

  task automatic wait_evt();
    for (int i = 0; i < 3000 && !mii_evt_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] cmd_a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mdc", 64'(mdc_o), 64'd0);
    check("R1 oe", 64'(mdio_oe), 64'd0);
    check("R1 mdio_o", 64'(mdio_o), 64'd1);
    check("R1 evt", 64'(mii_evt_o), 64'd0);
    for (int a = 0; a < 3; a++) begin
      rdreg(2'(a), rv);
      check("R1 register", 64'(rv), 64'd0);
    end
    // R2 R3 field placement in clock control
    wr(2'd1, 32'hFFFF_FFFF);
    rdreg(2'd1, rv);
    check("R2 R3 clock control readback", 64'(rv), 64'h77E);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op;
      logic [4:0]  phy, rg;
      logic [15:0] dat, pv;
      logic [5:0]  s;
      logic [2:0]  h;
      logic [31:0] cmd;
      logic [63:0] exp_frame;
      {op, phy, rg, dat, s, h, pv} = VEC[v];
      cmd = {2'b01, op, phy, rg, 2'b10, dat};
      exp_frame = {32'hFFFF_FFFF, cmd};
      wr(2'd1, (32'(s) << 1) | (32'(h) << 8));
      mon_clear(int'(h), pv);
      wr(2'd0, cmd);
      wait_evt();
      check("R4 rising edges", 64'(rise_cnt), 64'd64);
      check("R2 period min", 64'(per_min), 64'(2 * s));
      check("R2 period max", 64'(per_max), 64'(2 * s));
      check("R3 hold violations", 64'(hold_bad), 64'd0);
      check("R3 hold observed", 64'(hold_chk > 0), 64'd1);
      check("R7 event output", 64'(mii_evt_o), 64'd1);
      check("R10 mdc low", 64'(mdc_o), 64'd0);
      check("R10 oe low", 64'(mdio_oe), 64'd0);
      rdreg(2'd0, rv);
      if (op == 2'b10) begin
        check("R4 read frame header", frame_bits >> 18, exp_frame >> 18);
        check("R5 oe released tail", oe_bits & 64'h3FFFF, 64'd0);
        check("R5 read data", 64'(rv), 64'({cmd[31:16], pv}));
      end else begin
        check("R4 write frame", frame_bits, exp_frame);
        check("R4 oe held", oe_bits, {64{1'b1}});
        check("R6 data kept", 64'(rv), 64'(cmd));
      end
      rdreg(2'd2, rv);
      check("R7 event register", 64'(rv), 64'd1);
      if (v == 0) begin
        wr(2'd2, 32'h0);
        @(negedge clk);
        check("R7 write zero keeps", 64'(mii_evt_o), 64'd1);
      end
      wr(2'd2, 32'h1);
      @(negedge clk);
      check("R7 write one clears", 64'(mii_evt_o), 64'd0);
    end

    // R8 write during a frame
    cmd_a = {2'b01, 2'b01, 5'h07, 5'h05, 2'b10, 16'h5AA5};
    wr(2'd1, (32'd4 << 1) | (32'd1 << 8));
    mon_clear(1, 16'h0);
    wr(2'd0, cmd_a);
    repeat (40) @(negedge clk);
    wr(2'd0, {2'b01, 2'b10, 5'h1A, 5'h0C, 2'b10, 16'h0000});
    wait_evt();
    repeat (300) @(negedge clk);
    check("R8 single frame", 64'(rise_cnt), 64'd64);
    check("R8 frame content", frame_bits, {32'hFFFF_FFFF, cmd_a});
    rdreg(2'd0, rv);
    check("R8 data unchanged", 64'(rv), 64'(cmd_a));
    wr(2'd2, 32'h1);

    // R9 zero divider
    wr(2'd1, 32'h0);
    mon_clear(0, 16'h0);
    wr(2'd0, 32'h6123_0000);
    repeat (300) @(negedge clk);
    check("R9 no mdc", 64'(rise_cnt), 64'd0);
    check("R9 no event", 64'(mii_evt_o), 64'd0);
    rdreg(2'd0, rv);
    check("R9 data kept", 64'(rv), 64'(cmd_a));

    summary();
    $finish;
  end

endmodule